// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge

This block connects a synchronous request port to an external asynchronous static RAM that holds 262,144 bytes. A client offers one access at a time through a valid/ready handshake. The access carries a direction flag, an 18-bit address and, for writes, one data byte. The bridge then produces the strobe sequence the memory needs and, for reads, returns the fetched byte with a one-cycle valid pulse.

The memory answers only when its low-active select is low and its high-active select is high. A write takes effect only while both selects and the low-active write strobe are asserted together. All phase lengths are parameters in clock cycles. Each is the ceiling of a nanosecond requirement divided by the clock period, so the same RTL fits any clock by changing parameters.

The bus interface is split into an outgoing byte, an incoming byte and a drive enable. The pad ring combines them into the bidirectional data pins.

Top module: `sram_bridge`

## Requirements
- R1: During and right after reset, the low-active select is high, the high-active select is low, the write and output strobes are high, the data drive enable is low, `reqReady` is high and `rspValid` is low.
- R2: Whenever the write strobe or the output strobe is low, the low-active select is low and the high-active select is high.
- R3: An accepted read holds `memOeN` low and `memWeN` high for RD_CYCLES cycles (3 at defaults). It returns the addressed byte on `rspData` with `rspValid` high for exactly one cycle, namely the (RD_CYCLES+1)-th cycle after the accepting edge.
- R4: An accepted write holds `memWeN` low for exactly WR_CYCLES consecutive cycles (3 at defaults), with both selects asserted and the data drive enabled for the whole pulse, and the memory stores the request byte.
- R5: `memDqOe` is high exactly in the cycles where `memWeN` is low.
- R6: `memWeN` and `memOeN` are never low in the same cycle.
- R7: While `memWeN` stays low, `memAddr` and `memDqOut` do not change.
- R8: When a write is accepted in the first ready cycle after a read, `memOeN` is high for exactly TURN_CYCLES+2 cycles (3 at defaults) before `memWeN` falls. In every case, at least that many such cycles precede a fall of `memWeN`.
- R9: `reqReady` drops after an accepting edge and stays low for RD_CYCLES+TURN_CYCLES cycles after a read and WR_CYCLES+2 cycles after a write. Requests offered while it is low are ignored and leave memory unchanged.
- R10: `rspValid` never stays high two cycles in a row and never pulses for a write.
- R11: All 18 address bits reach `memAddr` unchanged during an access, including addresses 0x00000 and 0x3FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Bridge idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Byte address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle strobe for read data |
| rspData | output | 8 | Read byte |
| memAddr | output | 18 | Memory address pins |
| memCeN | output | 1 | Low-active memory select |
| memCe2 | output | 1 | High-active memory select |
| memWeN | output | 1 | Low-active write strobe |
| memOeN | output | 1 | Low-active output enable |
| memDqOut | output | 8 | Byte driven toward the memory |
| memDqOe | output | 1 | Drive enable for the data pins |
| memDqIn | input | 8 | Byte read from the data pins |

## Verification
The bench drives single reads, single writes, and writes read back at the lowest, highest and alternating-bit addresses. These show whether every address bit and data bit reaches the pins and returns intact. A read followed at once by a write probes the turnaround gap, which separates a bridge that releases the bus correctly from one that could contend with the memory. A write that is held busy while a second request is offered to another address shows whether requests leak in during an access. Pulse widths, busy lengths and the response cycle are counted at the pins, so an off-by-one in any phase counter shows up.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPULSE,
    ST_WREC
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch request fields
    logic sel;      // both memory selects asserted
    logic oe;       // output enable asserted
    logic we;       // write strobe asserted
    logic drive;    // drive data pins
    logic capture;  // sample read byte
  } strobeT;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_ctrl.sv
module sram_bridge_ctrl
  import sram_bridge_pkg::*;
#(
  parameter int RD_CYCLES   = 3,
  parameter int WR_CYCLES   = 3,
  parameter int TURN_CYCLES = 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output strobeT strobes
);

  localparam int MAX_CYC = maxInt(maxInt(RD_CYCLES, WR_CYCLES), TURN_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYCLES - 1);

  stateT state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt + 1'b1;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (reqValid) stateNext = reqWrite ? ST_WSET : ST_RD;
      end
      ST_RD: if (cnt == RD_LAST) begin
        stateNext = ST_TURN;
        cntNext   = '0;
      end
      ST_TURN: if (cnt == TURN_LAST) begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
      ST_WSET: begin
        stateNext = ST_WPULSE;
        cntNext   = '0;
      end
      ST_WPULSE: if (cnt == WR_LAST) begin
        stateNext = ST_WREC;
        cntNext   = '0;
      end
      ST_WREC: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
      default: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    reqReady        = (state == ST_IDLE);
    strobes.accept  = (state == ST_IDLE) && reqValid;
    strobes.sel     = (state == ST_RD) || (state == ST_WSET) ||
                      (state == ST_WPULSE) || (state == ST_WREC);
    strobes.oe      = (state == ST_RD);
    strobes.we      = (state == ST_WPULSE);
    strobes.drive   = (state == ST_WPULSE);
    strobes.capture = (state == ST_RD) && (cnt == RD_LAST);
  end

endmodule

// File: rtl/sram_bridge_dp.sv
module sram_bridge_dp
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobes.accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= strobes.capture;
      if (strobes.capture) rdataQ <= memDqIn;
    end
  end

  assign rspValid = rspQ;
  assign rspData  = rdataQ;
  assign memAddr  = addrQ;
  assign memCeN   = ~strobes.sel;
  assign memCe2   = strobes.sel;
  assign memWeN   = ~strobes.we;
  assign memOeN   = ~strobes.oe;
  assign memDqOut = wdataQ;
  assign memDqOe  = strobes.drive;

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 8,
  parameter int CLK_NS         = 20,
  parameter int RD_ACCESS_NS   = 55,
  parameter int RD_CYCLE_NS    = 55,
  parameter int WR_PULSE_NS    = 45,
  parameter int WR_DSETUP_NS   = 25,
  parameter int WR_SEL_END_NS  = 50,
  parameter int WR_CYCLE_NS    = 55,
  parameter int BUS_RELEASE_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  // select is asserted one cycle before the pulse, so the pulse covers the rest
  localparam int RD_CYCLES   = maxInt(nsToCycles(RD_ACCESS_NS, CLK_NS),
                                      nsToCycles(RD_CYCLE_NS, CLK_NS));
  localparam int WR_CYCLES   = maxInt(maxInt(nsToCycles(WR_PULSE_NS, CLK_NS),
                                             nsToCycles(WR_DSETUP_NS, CLK_NS)),
                                      maxInt(nsToCycles(WR_SEL_END_NS, CLK_NS) - 1,
                                             nsToCycles(WR_CYCLE_NS, CLK_NS) - 2));
  localparam int TURN_CYCLES = nsToCycles(BUS_RELEASE_NS, CLK_NS);

  strobeT strobes;

  sram_bridge_ctrl #(
    .RD_CYCLES  (RD_CYCLES),
    .WR_CYCLES  (WR_CYCLES),
    .TURN_CYCLES(TURN_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  sram_bridge_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rspValid(rspValid),
    .rspData (rspData),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memCe2  (memCe2),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int WR_CYCLES   = 3,
  parameter int TURN_CYCLES = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  logic [7:0] weLowCnt;
  logic [7:0] oeGap;
  logic       lastWasWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt     <= '0;
      oeGap        <= 8'hff;
      lastWasWrite <= 1'b0;
    end else begin
      weLowCnt <= memWeN ? 8'd0 : weLowCnt + 8'd1;
      if (!memOeN)             oeGap <= '0;
      else if (oeGap != 8'hff) oeGap <= oeGap + 8'd1;
      if (reqValid && reqReady) lastWasWrite <= reqWrite;
    end
  end

  assert_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memOeN) |-> (!memCeN && memCe2));

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == 8'(WR_CYCLES)));

  assert_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe == !memWeN);

  assert_no_fight_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  assert_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDqOut)));

  assert_turn_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> (oeGap >= 8'(TURN_CYCLES + 2)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_rsp_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !lastWasWrite);

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqWrite(reqWrite),
  .rspValid(rspValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memCe2  (memCe2),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDqOut(memDqOut),
  .memDqOe (memDqOe)
);

// File: tb/sram_bridge_tb.sv
`timescale 1ns/1ps
module sram_bridge_tb_top;

  localparam int CLK_NS = 20;
  localparam int RD_CYC = (55 + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC = (45 + CLK_NS - 1) / CLK_NS;
  localparam int TURN   = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [17:0] memAddr;
  logic        memCeN, memCe2, memWeN, memOeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sram_bridge dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model
  logic [7:0] memModel [int];

  function automatic logic [7:0] peek(input logic [17:0] a);
    if (memModel.exists(int'(a))) return memModel[int'(a)];
    return 8'h00;
  endfunction

  always_comb begin
    if (!memCeN && memCe2 && memWeN && !memOeN) memDqIn = peek(memAddr);
    else                                        memDqIn = 8'h00;
  end

  int cycNo = 0;
  int lastOeLow = -100;
  int gapSeen = -1;
  logic prevWeN = 1'b1;

  always @(negedge clk) begin
    cycNo++;
    if (!memCeN && memCe2 && !memWeN && memDqOe) memModel[int'(memAddr)] = memDqOut;
    if (!memOeN) lastOeLow = cycNo;
    if (!memWeN && prevWeN) gapSeen = cycNo - lastOeLow - 1;
    prevWeN = memWeN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller is at a negedge with reqReady high; returns at negedge after accept
  task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    repeat (2) @(negedge clk);
    check(memCeN && !memCe2 && memWeN && memOeN && !memDqOe, "R1 pins in reset",
          {memCeN, memCe2, memWeN, memOeN, memDqOe}, 5'b10110);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && memCeN && !memCe2 && !memDqOe, "R1 after reset",
          {reqReady, rspValid, memCeN, memCe2, memDqOe}, 5'b10100);
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [7:0] d);
    int n = 1, weLow = 0, bad = 0, rsp = 0, addrBad = 0;
    issue(1'b1, a, d);
    while (!reqReady && n < 64) begin
      if (!memWeN) begin
        weLow++;
        if (!memDqOe || memCeN || !memCe2) bad++;
        if (memAddr != a) addrBad++;
      end
      if (rspValid) rsp++;
      n++;
      @(negedge clk);
    end
    check(weLow == WR_CYC, "R4 write pulse length", weLow, WR_CYC);
    check(bad == 0, "R4 select and drive held in pulse", bad, 0);
    check(addrBad == 0, "R11 write address on pins", addrBad, 0);
    check(n - 1 == WR_CYC + 2, "R9 busy after write", n - 1, WR_CYC + 2);
    check(rsp == 0, "R10 no response for write", rsp, 0);
    check(peek(a) == d, "R4 byte stored", peek(a), d);
  endtask

  task automatic doRead(input logic [17:0] a, input logic [7:0] exp);
    int n = 1, oeLow = 0, pulses = 0, rspAt = 0, bad = 0;
    logic [7:0] got = '0;
    issue(1'b0, a, 8'h00);
    while (!reqReady && n < 64) begin
      if (!memOeN) begin
        oeLow++;
        if (memCeN || !memCe2 || !memWeN || memAddr != a) bad++;
      end
      if (rspValid) begin
        pulses++;
        rspAt = n;
        got = rspData;
      end
      n++;
      @(negedge clk);
    end
    check(oeLow == RD_CYC, "R3 output enable length", oeLow, RD_CYC);
    check(bad == 0, "R2 R11 select and address during read", bad, 0);
    check(pulses == 1, "R10 single response pulse", pulses, 1);
    check(rspAt == RD_CYC + 1, "R3 response cycle", rspAt, RD_CYC + 1);
    check(got == exp, "R3 read data", got, exp);
    check(n - 1 == RD_CYC + TURN, "R9 busy after read", n - 1, RD_CYC + TURN);
  endtask

  task automatic testReadThenWrite();
    doRead(18'h00012, peek(18'h00012));
    gapSeen = -1;
    doWrite(18'h00013, 8'h7E);
    check(gapSeen == TURN + 2, "R8 turnaround before write", gapSeen, TURN + 2);
  endtask

  task automatic testBusyIgnored();
    doWrite(18'h0BEEF, 8'h5A);
    issue(1'b1, 18'h00100, 8'h11);
    while (!reqReady) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h0BEEF; reqWdata = 8'hC3;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(peek(18'h0BEEF) == 8'h5A, "R9 busy request ignored", peek(18'h0BEEF), 8'h5A);
    doRead(18'h0BEEF, 8'h5A);
    doRead(18'h00100, 8'h11);
  endtask

  task automatic testBoundaries();
    doWrite(18'h00000, 8'hA5);
    doWrite(18'h3FFFF, 8'h3C);
    doWrite(18'h2AAAA, 8'hFF);
    doWrite(18'h15555, 8'h00);
    doRead(18'h00000, 8'hA5);
    doRead(18'h3FFFF, 8'h3C);
    doRead(18'h2AAAA, 8'hFF);
    doRead(18'h15555, 8'h00);
  endtask

  task automatic testOverwrite();
    doWrite(18'h01234, 8'h81);
    doWrite(18'h01234, 8'h18);
    doRead(18'h01234, 8'h18);
  endtask

  initial begin
    testReset();
    testBoundaries();
    testOverwrite();
    testReadThenWrite();
    testBusyIgnored();
    repeat (3) @(negedge clk);
    check(memCeN && !memCe2 && memWeN && memOeN && !memDqOe && reqReady,
          "R1 idle pins after traffic", {memCeN, memCe2, memWeN, memOeN, memDqOe}, 5'b10110);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule